// File: doc/BRIEF.md
# Twin Countdown Timer

This block is a register-mapped peripheral with two countdown channels, a free-running time counter and one level-sensitive interrupt line. Software sees 32-bit words on a plain valid/write/address bus. Each channel holds a reload value, a live count and a command register. A write to the command register carries an operation: load the reload value into the count, freeze the count, or let it run. The same write selects which of four external single-cycle tick enables drives the channel.

A running channel steps down by one on each selected tick. When a tick arrives with the count at one or zero, the count wraps back to the reload value and the channel's status bit latches, so the channel fires again every reload-value ticks. The status bits stay set until software writes ones to the acknowledge word. A mask word gates them onto the interrupt pin. The time counter advances on its own tick enable and can only be read.

Top module: `twin_countdown_timer`

## Requirements
- R1: After reset both counts, both reload values, both command registers, the status bits, the mask and the time counter read as zero, and `irq` is low.
- R2: A command write with operation code 0 in bits [1:0] copies the channel's reload value into its count. The command word reads back as the last legal value written, in bits [4:0]. Byte offsets for channel c are 0x10*c for the reload value, 0x10*c+0x04 for the count and 0x10*c+0x08 for the command.
- R3: Operation code 1 stops the channel, and its count then stays unchanged under ticks. Operation code 2 starts or resumes counting.
- R4: A running channel decrements on each selected tick. A tick that arrives with the count at 1 or 0 reloads the count from the reload value and sets status bit c (bit 0 for channel 0, bit 1 for channel 1).
- R5: Command bits [4:2] pick the tick source. Codes 4, 5, 6 and 7 select `tick_src[0]`, `tick_src[1]`, `tick_src[2]` and `tick_src[3]`. Codes 0 to 3 select no source, and the count does not advance.
- R6: A write to the reload value leaves the current count unchanged. The new value is used at the next load command or the next wrap.
- R7: A command write with operation code 3 is ignored: the command register, the count and the run state keep their values.
- R8: Writing the acknowledge word (0x4C) clears each status bit whose written bit is one and leaves the other bits alone. The acknowledge has no lasting effect, so a later expiry sets the bit again. The acknowledge word reads as zero.
- R9: The status word reads at 0x50, the mask at 0x48 and the masked status at 0x54 (status AND mask). `irq` is high exactly when the masked status is nonzero.
- R10: If an expiry and an acknowledge of the same bit fall in the same cycle, the bit stays set.
- R11: The time word at 0x38 adds one on each `time_tick` pulse, and writes to it are ignored.
- R12: Reads of any other offset, or of an offset with nonzero bits [1:0], return zero. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W (8) | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during a read access |
| tick_src | input | 4 | Four single-cycle tick enables for the channels |
| time_tick | input | 1 | Single-cycle enable for the time counter |
| irq | output | 1 | Level interrupt, high while any masked status bit is set |

## Verification
The hardest case to reach is a hardware expiry and an acknowledge of the same bit in one cycle. The bench first brings channel 0 to a count of one with a load and a single tick. It then puts the acknowledge write and the selected tick enable on the same clock edge, and reads back both the status word and the reloaded count. A second subtle case is a reload-value write while a channel runs mid-period. The bench reads the count right after that write, and again after the wrap, to show the old count survives and the new value appears only at the wrap.

// File: rtl/twin_tmr_pkg.sv
package twin_tmr_pkg;

    localparam int DATA_W    = 32;
    localparam int CH_COUNT  = 2;
    localparam int TICK_SRCS = 4;

    // word indices (byte offset / 4)
    localparam int CH_STRIDE  = 4;
    localparam int IDX_DIV    = 0;
    localparam int IDX_CNT    = 1;
    localparam int IDX_CTRL   = 2;
    localparam int IDX_TIME   = 'h0E;
    localparam int IDX_MASK   = 'h12;
    localparam int IDX_ACK    = 'h13;
    localparam int IDX_RAW    = 'h14;
    localparam int IDX_MASKED = 'h15;

    typedef enum logic [1:0] {
        OP_LOAD    = 2'd0,
        OP_HOLD    = 2'd1,
        OP_RUN     = 2'd2,
        OP_ILLEGAL = 2'd3
    } tmr_op_e;

    typedef struct packed {
        logic [2:0] src;
        tmr_op_e    op;
    } tmr_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);

    typedef struct packed {
        logic [CH_COUNT-1:0] div;
        logic [CH_COUNT-1:0] ctrl;
        logic                mask;
        logic                ack;
    } tmr_wr_t;

    // codes 4..7 map to the four tick enables, lower codes select nothing
    function automatic logic pick_tick(input logic [2:0] src,
                                       input logic [TICK_SRCS-1:0] ticks);
        return src[2] ? ticks[src[1:0]] : 1'b0;
    endfunction

endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
    import twin_tmr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output tmr_wr_t           wr,
    output logic              rd_en,
    output logic [ADDR_W-3:0] word_idx
);
    logic aligned;
    logic wr_en;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign word_idx = bus_addr[ADDR_W-1:2];
    assign wr_en    = bus_valid && bus_write && aligned;
    assign rd_en    = bus_valid && !bus_write && aligned;

    for (genvar g = 0; g < CH_COUNT; g++) begin : g_ch_dec
        assign wr.div[g]  = wr_en && (int'(word_idx) == g * CH_STRIDE + IDX_DIV);
        assign wr.ctrl[g] = wr_en && (int'(word_idx) == g * CH_STRIDE + IDX_CTRL);
    end

    assign wr.mask = wr_en && (int'(word_idx) == IDX_MASK);
    assign wr.ack  = wr_en && (int'(word_idx) == IDX_ACK);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import twin_tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 div_wr,
    input  logic [CNT_W-1:0]     div_in,
    input  logic                 ctrl_wr,
    input  tmr_ctrl_t            ctrl_in,
    input  logic [TICK_SRCS-1:0] ticks,
    output logic [CNT_W-1:0]     cnt_q,
    output logic [CNT_W-1:0]     div_q,
    output tmr_ctrl_t            ctrl_q,
    output logic                 running,
    output logic                 expire
);
    logic cmd_ok;
    logic tick_en;
    logic at_end;

    assign cmd_ok  = ctrl_wr && (ctrl_in.op != OP_ILLEGAL);
    assign tick_en = running && pick_tick(ctrl_q.src, ticks);
    assign at_end  = (cnt_q <= CNT_W'(1));
    // a command in the same cycle takes precedence over the tick
    assign expire  = tick_en && !cmd_ok && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            div_q   <= '0;
            ctrl_q  <= '{src: 3'd0, op: OP_LOAD};
            running <= 1'b0;
        end else begin
            if (div_wr) begin
                div_q <= div_in;
            end
            if (cmd_ok) begin
                ctrl_q <= ctrl_in;
                unique case (ctrl_in.op)
                    OP_LOAD: cnt_q   <= div_q;
                    OP_HOLD: running <= 1'b0;
                    OP_RUN:  running <= 1'b1;
                    default: ;
                endcase
            end else if (tick_en) begin
                cnt_q <= at_end ? div_q : cnt_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
    import twin_tmr_pkg::*;
#(
    parameter int N = CH_COUNT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         mask_wr,
    input  logic         ack_wr,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] raw_q,
    output logic [N-1:0] mask_q,
    output logic         irq
);
    logic [N-1:0] clr;

    assign clr = ack_wr ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr) | set;
            if (mask_wr) begin
                mask_q <= wbits;
            end
        end
    end

    assign irq = |(raw_q & mask_q);

endmodule

// File: rtl/twin_countdown_timer.sv
module twin_countdown_timer
    import twin_tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int TIME_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [TICK_SRCS-1:0] tick_src,
    input  logic                 time_tick,
    output logic                 irq
);
    tmr_wr_t             wr;
    logic                rd_en;
    logic [ADDR_W-3:0]   word_idx;

    logic [CNT_W-1:0]    ch_cnt  [CH_COUNT];
    logic [CNT_W-1:0]    ch_div  [CH_COUNT];
    tmr_ctrl_t           ch_ctrl [CH_COUNT];
    logic [CH_COUNT-1:0] ch_run;
    logic [CH_COUNT-1:0] ch_expire;
    logic [CH_COUNT-1:0] raw_w;
    logic [CH_COUNT-1:0] mask_w;
    logic [TIME_W-1:0]   time_q;

    tmr_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .wr        (wr),
        .rd_en     (rd_en),
        .word_idx  (word_idx)
    );

    for (genvar g = 0; g < CH_COUNT; g++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .div_wr  (wr.div[g]),
            .div_in  (bus_wdata[CNT_W-1:0]),
            .ctrl_wr (wr.ctrl[g]),
            .ctrl_in (tmr_ctrl_t'(bus_wdata[CTRL_W-1:0])),
            .ticks   (tick_src),
            .cnt_q   (ch_cnt[g]),
            .div_q   (ch_div[g]),
            .ctrl_q  (ch_ctrl[g]),
            .running (ch_run[g]),
            .expire  (ch_expire[g])
        );
    end

    tmr_irq_ctrl #(.N(CH_COUNT)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .set     (ch_expire),
        .mask_wr (wr.mask),
        .ack_wr  (wr.ack),
        .wbits   (bus_wdata[CH_COUNT-1:0]),
        .raw_q   (raw_w),
        .mask_q  (mask_w),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= '0;
        end else if (time_tick) begin
            time_q <= time_q + TIME_W'(1);
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            for (int c = 0; c < CH_COUNT; c++) begin
                if (int'(word_idx) == c * CH_STRIDE + IDX_DIV)
                    bus_rdata = DATA_W'(ch_div[c]);
                if (int'(word_idx) == c * CH_STRIDE + IDX_CNT)
                    bus_rdata = DATA_W'(ch_cnt[c]);
                if (int'(word_idx) == c * CH_STRIDE + IDX_CTRL)
                    bus_rdata = DATA_W'(ch_ctrl[c]);
            end
            if (int'(word_idx) == IDX_TIME)   bus_rdata = DATA_W'(time_q);
            if (int'(word_idx) == IDX_MASK)   bus_rdata = DATA_W'(mask_w);
            if (int'(word_idx) == IDX_RAW)    bus_rdata = DATA_W'(raw_w);
            if (int'(word_idx) == IDX_MASKED) bus_rdata = DATA_W'(raw_w & mask_w);
        end
    end

endmodule

// File: rtl/twin_tmr_chk.sv
module twin_tmr_chk
    import twin_tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int TIME_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_valid,
    input logic                bus_write,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                time_tick,
    input logic                irq,
    input logic [CH_COUNT-1:0] raw,
    input logic [CH_COUNT-1:0] mask,
    input logic [CH_COUNT-1:0] expire,
    input logic [CH_COUNT-1:0] run,
    input logic [CNT_W-1:0]    cnt0,
    input logic [TIME_W-1:0]   time_q
);
    logic wr_any;
    logic ack0;
    logic mask_zero_wr;
    logic ctrl0_wr;

    assign wr_any       = bus_valid && bus_write && (bus_addr[1:0] == 2'b00);
    assign ack0         = wr_any && (int'(bus_addr[ADDR_W-1:2]) == IDX_ACK) && bus_wdata[0];
    assign mask_zero_wr = wr_any && (int'(bus_addr[ADDR_W-1:2]) == IDX_MASK)
                          && (bus_wdata[CH_COUNT-1:0] == '0);
    assign ctrl0_wr     = wr_any && (int'(bus_addr[ADDR_W-1:2]) == IDX_CTRL);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (raw == '0) && (mask == '0) && !irq);

    // R10
    expire_sets_raw_chk: assert property (@(posedge clk) disable iff (rst)
        expire[0] |=> raw[0]);

    // R8
    raw_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (raw[0] && !ack0) |=> raw[0]);

    // R9
    mask_clear_irq_chk: assert property (@(posedge clk) disable iff (rst)
        mask_zero_wr |=> !irq);

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!run[0] && !ctrl0_wr) |=> $stable(cnt0));

    // R11
    time_step_chk: assert property (@(posedge clk) disable iff (rst)
        time_tick |=> (time_q == $past(time_q) + TIME_W'(1)));

    // R11
    time_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !time_tick |=> $stable(time_q));

endmodule

bind twin_countdown_timer twin_tmr_chk #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .TIME_W (TIME_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .time_tick (time_tick),
    .irq       (irq),
    .raw       (raw_w),
    .mask      (mask_w),
    .expire    (ch_expire),
    .run       (ch_run),
    .cnt0      (ch_cnt[0]),
    .time_q    (time_q)
);

// File: tb/twin_countdown_timer_test.sv
module twin_countdown_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  tick_src = '0;
    logic        time_tick = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    twin_countdown_timer uut (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_src  (tick_src),
        .time_tick (time_tick),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic tick(input int i);
        @(negedge clk);
        tick_src = 4'(1 << i);
        @(negedge clk);
        tick_src = '0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic test_reset;
        rd_check("R1 cnt0", 8'h04, 0);
        rd_check("R1 div1", 8'h10, 0);
        rd_check("R1 ctrl0", 8'h08, 0);
        rd_check("R1 raw", 8'h50, 0);
        rd_check("R1 mask", 8'h48, 0);
        rd_check("R1 time", 8'h38, 0);
        check("R1 irq", 32'(irq), 0);
    endtask

    task automatic test_load;
        wr(8'h00, 3);
        wr(8'h08, 32'h10);
        rd_check("R2 load count", 8'h04, 3);
        rd_check("R2 ctrl readback", 8'h08, 32'h10);
        rd_check("R2 div readback", 8'h00, 3);
    endtask

    task automatic test_run;
        wr(8'h08, 32'h12);
        tick(0); tick(0);
        rd_check("R4 count after two ticks", 8'h04, 1);
        rd_check("R4 no status yet", 8'h50, 0);
        tick(0);
        rd_check("R4 reload on expiry", 8'h04, 3);
        rd_check("R4 status bit0", 8'h50, 1);
        check("R9 irq masked off", 32'(irq), 0);
    endtask

    task automatic test_mask_ack;
        wr(8'h48, 1);
        @(negedge clk);
        check("R9 irq with mask", 32'(irq), 1);
        rd_check("R9 masked status", 8'h54, 1);
        wr(8'h48, 2);
        @(negedge clk);
        check("R9 irq other mask", 32'(irq), 0);
        rd_check("R9 masked other", 8'h54, 0);
        wr(8'h48, 1);
        wr(8'h4C, 2);
        rd_check("R8 ack other bit", 8'h50, 1);
        @(negedge clk);
        check("R8 irq kept", 32'(irq), 1);
        wr(8'h4C, 1);
        rd_check("R8 ack clears", 8'h50, 0);
        @(negedge clk);
        check("R8 irq low after ack", 32'(irq), 0);
        rd_check("R8 ack reads zero", 8'h4C, 0);
        tick(0); tick(0); tick(0);
        rd_check("R8 re-set after ack", 8'h50, 1);
        wr(8'h4C, 1);
    endtask

    task automatic test_hold;
        wr(8'h08, 32'h11);
        tick(0); tick(0);
        rd_check("R3 hold keeps count", 8'h04, 3);
        wr(8'h08, 32'h12);
        tick(0);
        rd_check("R3 resume", 8'h04, 2);
    endtask

    task automatic test_div_running;
        wr(8'h00, 5);
        rd_check("R6 count unchanged", 8'h04, 2);
        tick(0);
        rd_check("R6 old period", 8'h04, 1);
        tick(0);
        rd_check("R6 new reload", 8'h04, 5);
        wr(8'h4C, 3);
    endtask

    task automatic test_illegal;
        wr(8'h08, 32'h13);
        rd_check("R7 ctrl kept", 8'h08, 32'h12);
        tick(0);
        rd_check("R7 still running", 8'h04, 4);
    endtask

    task automatic test_source;
        wr(8'h10, 2);
        wr(8'h18, 32'h1C);
        wr(8'h18, 32'h1E);
        tick(0);
        rd_check("R5 ch1 ignores src0", 8'h14, 2);
        rd_check("R5 ch0 uses src0", 8'h04, 3);
        tick(3);
        rd_check("R5 ch1 uses src3", 8'h14, 1);
        tick(3);
        rd_check("R5 ch1 reload", 8'h14, 2);
        rd_check("R4 status bit1", 8'h50, 2);
        wr(8'h08, 32'h06);
        tick(0); tick(1); tick(2);
        rd_check("R5 code1 no advance", 8'h04, 3);
        wr(8'h4C, 3);
    endtask

    task automatic test_collision;
        wr(8'h00, 2);
        wr(8'h08, 32'h10);
        wr(8'h08, 32'h12);
        tick(0);
        rd_check("R10 setup count", 8'h04, 1);
        wr(8'h4C, 3);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h4C; bus_wdata = 1;
        tick_src = 4'b0001;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; tick_src = '0;
        rd_check("R10 set wins", 8'h50, 1);
        rd_check("R10 reloaded", 8'h04, 2);
        wr(8'h4C, 3);
    endtask

    task automatic test_time;
        rd_check("R11 time idle", 8'h38, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); time_tick = 1'b1;
            @(negedge clk); time_tick = 1'b0;
        end
        rd_check("R11 time counts", 8'h38, 4);
        wr(8'h38, 32'hFFFF);
        rd_check("R11 write ignored", 8'h38, 4);
    endtask

    task automatic test_unmapped;
        rd_check("R12 offset 0x0C", 8'h0C, 0);
        rd_check("R12 offset 0x20", 8'h20, 0);
        rd_check("R12 misaligned", 8'h05, 0);
        wr(8'h20, 32'hFFFFFFFF);
        wr(8'h01, 32'hFFFFFFFF);
        rd_check("R12 div0 untouched", 8'h00, 2);
        rd_check("R12 mask untouched", 8'h48, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_load();
        test_run();
        test_mask_ack();
        test_hold();
        test_div_running();
        test_illegal();
        test_source();
        test_collision();
        test_time();
        test_unmapped();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule